// File: doc/BRIEF.md
# Shared Multiplier Arbiter with CPU-First Polling

This block lets two processor cores and one background accelerator share a single 32x32 multiplier. Each core reaches the multiplier through two request queues, one for integer work and one for floating-point-class work; the floating-point queue is treated as a second integer path carrying plain operands. Every queue has a matching response queue that receives the 64-bit product. Queue-full flags are the only backpressure toward the cores.

An arbiter picks at most one request per cycle. It scans the four CPU queues in a fixed order and skips any that are empty. The accelerator can use the multiplier only in a cycle where all four CPU request queues are empty. When it is refused, it sees a stall flag and holds its operands. A build-time option makes the arbiter swap which core it checks first on every cycle, so that two cores with constant backlogs share the multiplier evenly.

Top module: `mshr_shared_mul`

## Requirements
- R1: After reset, every request queue reports not-full, every response queue reports empty, and the accelerator sees no grant, no stall and no product.
- R2: A request is served as the unsigned 64-bit product of its two 32-bit operands. The product is placed in the response queue of the same channel and is visible there on the second clock edge after the edge that accepted the push.
- R3: The channel indices are 0 = core0 integer, 1 = core0 floating-point, 2 = core1 integer and 3 = core1 floating-point. In the default mode the lowest-indexed eligible channel wins, so core0 goes first when both cores push on the same edge.
- R4: At most one request, from either the CPUs or the accelerator, is served per cycle. When all four channels are loaded on the same edge, their products appear one per cycle in index order.
- R5: acc_grant is high only while acc_req is high and all four CPU request queues are empty. acc_stall is high when acc_req is high and no grant is given. The product of a granted cycle shows on acc_prod with acc_prod_vld on the next cycle.
- R6: A held accelerator request adds no cycles to the latency of a CPU request. The CPU result still appears on the second edge after its push.
- R7: A request queue holds 4 entries and raises req_full when it holds 4. A push while it is full is dropped and leaves the queue unchanged.
- R8: A channel whose response queue has no room, counting a product already in flight, is not served. Its requests wait in the request queue, and the other channels keep being served.
- R9: Responses on a channel come out in the order their requests were pushed.
- R10: With ALT_CORE=1, the core checked first swaps every cycle. When both cores keep their integer queues loaded, core1 gets products before core0 has drained its backlog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_push | input | 4 | Push strobe per CPU channel |
| req_a | input | 4x32 | First operand per channel |
| req_b | input | 4x32 | Second operand per channel |
| req_full | output | 4 | Request queue full per channel |
| rsp_pop | input | 4 | Pop strobe per response queue |
| rsp_valid | output | 4 | Response queue non-empty |
| rsp_data | output | 4x64 | Head product per response queue |
| acc_req | input | 1 | Accelerator wants the multiplier this cycle |
| acc_a | input | 32 | Accelerator first operand |
| acc_b | input | 32 | Accelerator second operand |
| acc_grant | output | 1 | Accelerator operands consumed this cycle |
| acc_stall | output | 1 | Accelerator refused; hold operands |
| acc_prod_vld | output | 1 | Accelerator product valid |
| acc_prod | output | 64 | Accelerator product |

## Verification
If the scan order or the rotation bit goes wrong, products show up on rsp_valid in the wrong order. The misorder is visible within two or three cycles of loading several channels at once. A wrong view of queue occupancy shows up as one of three faults at the ports: acc_grant raised while a CPU request is pending, a product lost because its response queue was full, or a push that should have been dropped returning an extra result. A bad pointer in any queue shows up as a wrong or reordered product the next time that channel is popped.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
    localparam int NUM_CORES  = 2;
    localparam int KINDS      = 2;
    localparam int NUM_CH     = NUM_CORES * KINDS;
    localparam int CH_IDX_W   = $clog2(NUM_CH);
    localparam int CORE_STEP  = KINDS;
endpackage

// File: rtl/mshr_fifo.sv
module mshr_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;

    // R7: occupancy never exceeds the configured depth
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R7: a push into a full queue without a pop leaves it full and unchanged in size
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(st_q.wp)));
endmodule

// File: rtl/mshr_poll_arb.sv
module mshr_poll_arb
    import mshr_pkg::*;
#(
    parameter bit ALT_CORE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] elig,
    input  logic [NUM_CH-1:0] req_empty,
    input  logic              acc_req,
    output logic [NUM_CH-1:0] grant,
    output logic              acc_grant
);
    typedef struct packed {
        logic flip;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    found;
    int      start;
    int      idx;

    always_comb begin
        st_d      = st_q;
        st_d.flip = ALT_CORE ? !st_q.flip : 1'b0;
        grant     = '0;
        found     = 1'b0;
        start     = st_q.flip ? CORE_STEP : 0;
        idx       = 0;
        for (int k = 0; k < NUM_CH; k++) begin
            idx = (start + k) % NUM_CH;
            if (!found && elig[idx]) begin
                grant[idx] = 1'b1;
                found      = 1'b1;
            end
        end
        acc_grant = acc_req && (&req_empty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a single requester wins in any cycle
    p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, acc_grant}));

    // R5: accelerator only wins when every CPU request queue is empty
    p_acc_idle_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> (req_empty == '1));

    // R3: a granted CPU channel always had something to serve
    p_grant_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((grant & req_empty) == '0));
endmodule

// File: rtl/mshr_mul_dp.sv
module mshr_mul_dp #(
    parameter int OP_W  = 32,
    parameter int TAG_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              is_acc,
    input  logic [TAG_W-1:0]  tag,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic              vld,
    output logic              vld_acc,
    output logic [TAG_W-1:0]  vld_tag,
    output logic [2*OP_W-1:0] prod
);
    typedef struct packed {
        logic              vld;
        logic              is_acc;
        logic [TAG_W-1:0]  tag;
        logic [2*OP_W-1:0] prod;
    } dp_st_t;

    dp_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.vld    = fire;
        st_d.is_acc = fire && is_acc;
        if (fire) begin
            st_d.tag  = tag;
            st_d.prod = (2*OP_W)'(op_a) * (2*OP_W)'(op_b);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld     = st_q.vld;
    assign vld_acc = st_q.vld && st_q.is_acc;
    assign vld_tag = st_q.tag;
    assign prod    = st_q.prod;

    // R2: each served operand pair yields its product one cycle later
    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> vld);
endmodule

// File: rtl/mshr_shared_mul.sv
module mshr_shared_mul
    import mshr_pkg::*;
#(
    parameter int OP_W      = 32,
    parameter int REQ_DEPTH = 4,
    parameter int RSP_DEPTH = 4,
    parameter bit ALT_CORE  = 1'b0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CH-1:0]                req_push,
    input  logic [NUM_CH-1:0][OP_W-1:0]      req_a,
    input  logic [NUM_CH-1:0][OP_W-1:0]      req_b,
    output logic [NUM_CH-1:0]                req_full,
    input  logic [NUM_CH-1:0]                rsp_pop,
    output logic [NUM_CH-1:0]                rsp_valid,
    output logic [NUM_CH-1:0][2*OP_W-1:0]    rsp_data,
    input  logic                             acc_req,
    input  logic [OP_W-1:0]                  acc_a,
    input  logic [OP_W-1:0]                  acc_b,
    output logic                             acc_grant,
    output logic                             acc_stall,
    output logic                             acc_prod_vld,
    output logic [2*OP_W-1:0]                acc_prod
);
    localparam int PW      = 2 * OP_W;
    localparam int REQ_CW  = $clog2(REQ_DEPTH + 1);
    localparam int RSP_CW  = $clog2(RSP_DEPTH + 1);

    logic [NUM_CH-1:0]              req_empty;
    logic [NUM_CH-1:0][PW-1:0]      req_head;
    logic [NUM_CH-1:0][REQ_CW-1:0]  req_cnt;
    logic [NUM_CH-1:0]              rsp_empty;
    logic [NUM_CH-1:0]              rsp_full;
    logic [NUM_CH-1:0][RSP_CW-1:0]  rsp_cnt;
    logic [NUM_CH-1:0]              rsp_push;
    logic [NUM_CH-1:0]              elig;
    logic [NUM_CH-1:0]              grant;
    logic                           arb_acc_grant;

    logic                           dp_vld;
    logic                           dp_vld_acc;
    logic [CH_IDX_W-1:0]            dp_tag;
    logic [PW-1:0]                  dp_prod;

    logic                           sel_fire;
    logic [CH_IDX_W-1:0]            sel_tag;
    logic [OP_W-1:0]                sel_a;
    logic [OP_W-1:0]                sel_b;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic inflight;

        mshr_fifo #(.WIDTH(PW), .DEPTH(REQ_DEPTH)) u_req (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (req_push[i]),
            .wdata ({req_a[i], req_b[i]}),
            .pop   (grant[i]),
            .rdata (req_head[i]),
            .empty (req_empty[i]),
            .full  (req_full[i]),
            .count (req_cnt[i])
        );

        mshr_fifo #(.WIDTH(PW), .DEPTH(RSP_DEPTH)) u_rsp (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (rsp_push[i]),
            .wdata (dp_prod),
            .pop   (rsp_pop[i]),
            .rdata (rsp_data[i]),
            .empty (rsp_empty[i]),
            .full  (rsp_full[i]),
            .count (rsp_cnt[i])
        );

        assign inflight    = dp_vld && !dp_vld_acc && (dp_tag == CH_IDX_W'(i));
        assign rsp_push[i] = inflight;
        assign rsp_valid[i] = !rsp_empty[i];
        assign elig[i]     = !req_empty[i] &&
                             (({1'b0, rsp_cnt[i]} + (RSP_CW+1)'(inflight)) < (RSP_CW+1)'(RSP_DEPTH));

        // R8: a product is never pushed into a response queue without room
        p_rsp_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_push[i] |-> !rsp_full[i]);
    end

    mshr_poll_arb #(.ALT_CORE(ALT_CORE)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .req_empty (req_empty),
        .acc_req   (acc_req),
        .grant     (grant),
        .acc_grant (arb_acc_grant)
    );

    always_comb begin
        sel_fire = arb_acc_grant || (grant != '0);
        sel_tag  = '0;
        sel_a    = acc_a;
        sel_b    = acc_b;
        for (int k = 0; k < NUM_CH; k++) begin
            if (grant[k]) begin
                sel_tag = CH_IDX_W'(k);
                sel_a   = req_head[k][PW-1:OP_W];
                sel_b   = req_head[k][OP_W-1:0];
            end
        end
    end

    mshr_mul_dp #(.OP_W(OP_W), .TAG_W(CH_IDX_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (sel_fire),
        .is_acc  (arb_acc_grant),
        .tag     (sel_tag),
        .op_a    (sel_a),
        .op_b    (sel_b),
        .vld     (dp_vld),
        .vld_acc (dp_vld_acc),
        .vld_tag (dp_tag),
        .prod    (dp_prod)
    );

    assign acc_grant    = arb_acc_grant;
    assign acc_stall    = acc_req && !arb_acc_grant;
    assign acc_prod_vld = dp_vld_acc;
    assign acc_prod     = dp_prod;

    // R5: a granted accelerator cycle delivers its product next cycle
    p_acc_prod_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |=> acc_prod_vld);

    // R6: a pending CPU request means no accelerator product follows
    p_cpu_blocks_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_empty != '1) |=> !acc_prod_vld);
endmodule

// File: tb/tb_mshr_shared_mul.sv
module tb_mshr_shared_mul;
    logic              clk = 1'b0;
    logic              rst_n;
    logic [3:0]        req_push;
    logic [3:0][31:0]  req_a, req_b;
    logic [3:0]        rsp_pop;
    logic              acc_req;
    logic [31:0]       acc_a, acc_b;

    logic [3:0]        req_full, f_req_full;
    logic [3:0]        rsp_valid, f_rsp_valid;
    logic [3:0][63:0]  rsp_data, f_rsp_data;
    logic              acc_grant, acc_stall, acc_prod_vld;
    logic [63:0]       acc_prod;
    logic              x_grant, x_stall, x_prod_vld;
    logic [63:0]       x_prod;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = !clk;

    mshr_shared_mul dut (
        .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_a(req_a), .req_b(req_b),
        .req_full(req_full), .rsp_pop(rsp_pop), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .acc_req(acc_req), .acc_a(acc_a), .acc_b(acc_b), .acc_grant(acc_grant),
        .acc_stall(acc_stall), .acc_prod_vld(acc_prod_vld), .acc_prod(acc_prod)
    );

    mshr_shared_mul #(.ALT_CORE(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_a(req_a), .req_b(req_b),
        .req_full(f_req_full), .rsp_pop(rsp_pop), .rsp_valid(f_rsp_valid), .rsp_data(f_rsp_data),
        .acc_req(acc_req), .acc_a(acc_a), .acc_b(acc_b), .acc_grant(x_grant),
        .acc_stall(x_stall), .acc_prod_vld(x_prod_vld), .acc_prod(x_prod)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mul(input logic [31:0] a, input logic [31:0] b);
        return {32'd0, a} * {32'd0, b};
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pop_check(input int ch, input logic [63:0] exp, input string req, input bit alt);
        chk(rsp_valid[ch] && rsp_data[ch] == exp, req, "response value", rsp_data[ch], exp);
        if (alt) chk(f_rsp_valid[ch] && f_rsp_data[ch] == exp, req, "alt response value",
                     f_rsp_data[ch], exp);
        rsp_pop[ch] = 1'b1;
        tick(1);
        rsp_pop[ch] = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_push = '0; req_a = '0; req_b = '0; rsp_pop = '0;
        acc_req = 1'b0; acc_a = '0; acc_b = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk(req_full == 4'b0, "R1", "req_full after reset", 64'(req_full), 64'h0);
        chk(rsp_valid == 4'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
        chk({acc_grant, acc_stall, acc_prod_vld} == 3'b0, "R1", "accel flags after reset",
            64'({acc_grant, acc_stall, acc_prod_vld}), 64'h0);
    endtask

    task automatic single(input int ch, input logic [31:0] a, input logic [31:0] b);
        req_push[ch] = 1'b1; req_a[ch] = a; req_b[ch] = b;
        tick(1);
        req_push[ch] = 1'b0;
        tick(1);
        chk(!rsp_valid[ch], "R2", "result too early", 64'(rsp_valid[ch]), 64'h0);
        tick(1);
        pop_check(ch, mul(a, b), "R2", 1'b0);
    endtask

    task automatic t_single();
        single(0, 32'd3, 32'd5);
        single(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        single(2, 32'd0, 32'h1234_5678);
        single(3, 32'h8000_0000, 32'd2);
    endtask

    task automatic t_order();
        req_push = 4'hF;
        for (int i = 0; i < 4; i++) begin
            req_a[i] = 32'(100 + i); req_b[i] = 32'd7;
        end
        tick(1);
        req_push = '0;
        tick(1);
        chk(rsp_valid == 4'b0000, "R4", "no result yet", 64'(rsp_valid), 64'h0);
        tick(1);
        chk(rsp_valid == 4'b0001, "R3", "core0 integer first", 64'(rsp_valid), 64'h1);
        tick(1);
        chk(rsp_valid == 4'b0011, "R4", "one per cycle", 64'(rsp_valid), 64'h3);
        tick(1);
        chk(rsp_valid == 4'b0111, "R3", "core1 integer third", 64'(rsp_valid), 64'h7);
        tick(1);
        chk(rsp_valid == 4'b1111, "R4", "all served", 64'(rsp_valid), 64'hF);
        for (int i = 0; i < 4; i++) pop_check(i, mul(32'(100 + i), 32'd7), "R3", 1'b0);
    endtask

    task automatic t_acc();
        acc_req = 1'b1; acc_a = 32'd7; acc_b = 32'd9;
        tick(1);
        chk(acc_grant && !acc_stall, "R5", "grant when idle", 64'({acc_grant, acc_stall}), 64'h2);
        chk(acc_prod_vld && acc_prod == 64'd63, "R5", "accel product", acc_prod, 64'd63);
        acc_a = 32'd4; acc_b = 32'd4;
        req_push[0] = 1'b1; req_a[0] = 32'd11; req_b[0] = 32'd2;
        tick(1);
        req_push[0] = 1'b0;
        chk(!acc_grant && acc_stall, "R5", "stall while CPU pending", 64'({acc_grant, acc_stall}), 64'h1);
        chk(acc_prod_vld && acc_prod == 64'd16, "R5", "last accel product", acc_prod, 64'd16);
        tick(1);
        chk(acc_grant && !acc_stall, "R5", "grant after CPU drained", 64'({acc_grant, acc_stall}), 64'h2);
        chk(!acc_prod_vld, "R5", "no accel product after stall", 64'(acc_prod_vld), 64'h0);
        chk(!rsp_valid[0], "R6", "CPU result not yet", 64'(rsp_valid[0]), 64'h0);
        tick(1);
        chk(acc_prod_vld && acc_prod == 64'd16, "R5", "held operands used", acc_prod, 64'd16);
        pop_check(0, 64'd22, "R6", 1'b0);
        acc_req = 1'b0;
        tick(2);
    endtask

    task automatic t_full();
        for (int k = 0; k < 4; k++) begin
            req_push[1] = 1'b1; req_a[1] = 32'(10 + k); req_b[1] = 32'd3;
            tick(1);
        end
        req_push[1] = 1'b0;
        tick(4);
        for (int k = 0; k < 4; k++) begin
            if (k == 3) chk(!req_full[1], "R7", "not full at 3", 64'(req_full[1]), 64'h0);
            req_push[1] = 1'b1; req_a[1] = 32'(20 + k); req_b[1] = 32'd3;
            tick(1);
        end
        chk(req_full[1], "R7", "full at 4", 64'(req_full[1]), 64'h1);
        req_a[1] = 32'd99;
        tick(1);
        req_push[1] = 1'b0;
        chk(req_full[1], "R8", "blocked channel keeps requests", 64'(req_full[1]), 64'h1);
        req_push[2] = 1'b1; req_a[2] = 32'd5; req_b[2] = 32'd7;
        tick(1);
        req_push[2] = 1'b0;
        tick(2);
        pop_check(2, 64'd35, "R8", 1'b0);
        chk(req_full[1], "R8", "still blocked", 64'(req_full[1]), 64'h1);
        for (int k = 0; k < 4; k++) pop_check(1, mul(32'(10 + k), 32'd3), "R9", 1'b0);
        tick(4);
        for (int k = 0; k < 4; k++) pop_check(1, mul(32'(20 + k), 32'd3), "R9", 1'b0);
        tick(4);
        chk(!rsp_valid[1], "R7", "dropped push left no result", 64'(rsp_valid[1]), 64'h0);
        chk(!req_full[1], "R7", "queue drained", 64'(req_full[1]), 64'h0);
    endtask

    task automatic t_alt();
        do_reset();
        for (int k = 0; k < 4; k++) begin
            req_push = 4'b0101;
            req_a[0] = 32'(40 + k); req_b[0] = 32'd2;
            req_a[2] = 32'(60 + k); req_b[2] = 32'd2;
            tick(1);
        end
        req_push = '0;
        tick(1);
        chk(!rsp_valid[2], "R3", "fixed mode core1 waits", 64'(rsp_valid[2]), 64'h0);
        chk(f_rsp_valid[2], "R10", "alternating mode core1 served", 64'(f_rsp_valid[2]), 64'h1);
        tick(10);
        chk(rsp_valid == 4'b0101 && f_rsp_valid == 4'b0101, "R10", "both complete",
            64'({rsp_valid, f_rsp_valid}), 64'h55);
        for (int k = 0; k < 4; k++) pop_check(0, mul(32'(40 + k), 32'd2), "R10", 1'b1);
        for (int k = 0; k < 4; k++) pop_check(2, mul(32'(60 + k), 32'd2), "R10", 1'b1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_order();
        t_acc();
        t_full();
        t_alt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule